// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. It gathers eleven request sources, two of them external pins and nine internal event strobes. Each source keeps a request flag, has its own enable bit and carries a two-bit priority level. Once per machine cycle the flags are copied into a pending snapshot. At every instruction boundary the controller picks the highest-level enabled pending source and issues a forced call to that source's fixed vector.

The controller keeps a four-bit in-service mask, one bit for each priority level. A new request can nest only if its level is strictly above every level already in service. A return-from-interrupt strobe closes the highest active level. Instruction decoding happens elsewhere. The instruction boundary, the return strobe and writes to the enable or priority registers reach this block as single-bit inputs.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `ack_valid`, `ack_src`, `ack_vec`, `ack_level` and `in_service` are all zero. With both external pins high, `req_flags` is zero.
- R2: `req_flags[i]` rises on the clock edge that sees the source's event, whether or not `src_en[i]` is set. Source i≥2 is driven by `int_evt[i-2]`. Sources 0 and 1 are the external pins `ext_n[0]` and `ext_n[1]`.
- R3: The pending snapshot copies `req_flags` only on edges where `sample_tick` is high. The grant decision uses the snapshot as it stood before that edge.
- R4: A pending source whose `src_en` bit is low is never granted.
- R5: The granted source has the highest level {`prio_hi[i]`,`prio_lo[i]`} (3 is highest). Among sources at that level, the lowest index wins.
- R6: A grant shows on the edge after the decision. `ack_valid` pulses for one cycle, with `ack_src`, `ack_level` and `ack_vec` = 0x0003 + 8·index.
- R7: A grant happens only if the winner's level is strictly above the highest set bit of `in_service`, or if `in_service` is zero. The grant sets `in_service[level]`.
- R8: No grant is made in a cycle without `insn_boundary`, or in a cycle where `cfg_write` or `reti_pulse` is high.
- R9: `reti_pulse` clears the highest set bit of `in_service`. It has no effect when the mask is zero.
- R10: With `ext_edge[k]`=1 the external flag is set by a falling edge of `ext_n[k]` between two clock samples. It is cleared when source k is granted.
- R11: With `ext_edge[k]`=0 the request equals the inverted pin, registered by one clock, with no latch. A grant does not clear it.
- R12: An internal flag is cleared when its source is granted. A new event in the same cycle wins and leaves the flag set. A granted source's snapshot bit is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_evt | input | NUM_SRC-2 | Internal event strobes for sources 2 and up |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Trigger type per pin: 1 = falling edge, 0 = low level |
| src_en | input | NUM_SRC | Per-source enable |
| prio_hi | input | NUM_SRC | Upper priority bit per source |
| prio_lo | input | NUM_SRC | Lower priority bit per source |
| sample_tick | input | 1 | Machine-cycle strobe that loads the pending snapshot |
| insn_boundary | input | 1 | Instruction boundary where a call may be forced |
| cfg_write | input | 1 | Current instruction writes the enable or priority registers |
| reti_pulse | input | 1 | Current instruction is a return from interrupt |
| req_flags | output | NUM_SRC | Live request state per source |
| ack_valid | output | 1 | One-cycle grant strobe |
| ack_src | output | SRC_W | Granted source index |
| ack_level | output | 2 | Granted priority level |
| ack_vec | output | VEC_W | Call target address |
| in_service | output | NUM_LVL | Levels currently in service |

## Verification
On every cycle the assertions check the following. A grant always follows an enabled source at a boundary that was not blocked. The granted level is strictly above all levels that were in service before it, and its bit is then set. A return removes exactly one level. A level-mode pin request tracks the pin with a one-clock lag. Winner selection among ties and mixed levels, the snapshot timing against `sample_tick`, the way edge flags and internal flags clear or survive a grant, and the vector values can only be shown by the bench scenarios. The bench compares every output against a reference model, on each cycle, under random and directed stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Index of the highest set bit of a mask (0 when the mask is empty).
   function automatic int unsigned top_bit(input logic [31:0] mask, input int unsigned width);
      int unsigned r;
      r = 0;
      for (int unsigned b = 0; b < width; b++)
         if (mask[b]) r = b;
      return r;
   endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
   parameter int NUM_SRC = 11,
   parameter int NUM_EXT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-NUM_EXT-1:0] int_evt,
   input  logic [NUM_EXT-1:0] ext_n,
   input  logic [NUM_EXT-1:0] ext_edge,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] req
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g < NUM_EXT) begin : g_ext
         logic pin_q;
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin_q  <= 1'b1;
               flag_q <= 1'b0;
            end else begin
               pin_q  <= ext_n[g];
               flag_q <= ext_edge[g] ? ((pin_q & ~ext_n[g]) | (flag_q & ~clr[g])) : 1'b0;
            end
         end
         assign req[g] = ext_edge[g] ? flag_q : ~pin_q;
      end else begin : g_int
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= int_evt[g-NUM_EXT] | (flag_q & ~clr[g]);
         end
         assign req[g] = flag_q;
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NUM_SRC = 11,
   parameter int NUM_LVL = 4,
   localparam int SRC_W = $clog2(NUM_SRC),
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic [NUM_SRC-1:0] cand,
   input  logic [NUM_SRC-1:0] prio_hi,
   input  logic [NUM_SRC-1:0] prio_lo,
   output logic               found,
   output logic [SRC_W-1:0]   win_src,
   output logic [LVL_W-1:0]   win_lvl
);
   logic [LVL_W-1:0] lvl_of [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
      assign lvl_of[g] = {prio_hi[g], prio_lo[g]};
   end

   // Levels scanned from the top down, sources from index 0 up.
   always_comb begin
      found   = 1'b0;
      win_src = '0;
      win_lvl = '0;
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && cand[i] && lvl_of[i] == LVL_W'(l)) begin
               found   = 1'b1;
               win_src = SRC_W'(i);
               win_lvl = LVL_W'(l);
            end
         end
      end
   end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
   parameter int NUM_LVL = 4,
   localparam int LVL_W = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               grant,
   input  logic [LVL_W-1:0]   grant_lvl,
   input  logic               reti,
   output logic [NUM_LVL-1:0] isr,
   output logic               busy,
   output logic [LVL_W-1:0]   top_lvl
);
   import irq_pkg::*;

   logic [NUM_LVL-1:0] isr_q;

   assign busy    = |isr_q;
   assign top_lvl = LVL_W'(top_bit(32'(isr_q), NUM_LVL));
   assign isr     = isr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         isr_q <= '0;
      else if (grant)
         isr_q <= isr_q | (NUM_LVL'(1) << grant_lvl);
      else if (reti && busy)
         isr_q <= isr_q & ~(NUM_LVL'(1) << top_lvl);
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int NUM_SRC    = 11,
   parameter int NUM_LVL    = 4,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   localparam int NUM_EXT   = 2,
   localparam int SRC_W     = $clog2(NUM_SRC),
   localparam int LVL_W     = $clog2(NUM_LVL)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-NUM_EXT-1:0] int_evt,
   input  logic [NUM_EXT-1:0]         ext_n,
   input  logic [NUM_EXT-1:0]         ext_edge,
   input  logic [NUM_SRC-1:0]         src_en,
   input  logic [NUM_SRC-1:0]         prio_hi,
   input  logic [NUM_SRC-1:0]         prio_lo,
   input  logic                       sample_tick,
   input  logic                       insn_boundary,
   input  logic                       cfg_write,
   input  logic                       reti_pulse,
   output logic [NUM_SRC-1:0]         req_flags,
   output logic                       ack_valid,
   output logic [SRC_W-1:0]           ack_src,
   output logic [LVL_W-1:0]           ack_level,
   output logic [VEC_W-1:0]           ack_vec,
   output logic [NUM_LVL-1:0]         in_service
);
   if (NUM_LVL != 4) begin : g_bad_lvl
      $error("irq_ctrl: two priority bits per source need NUM_LVL == 4");
   end
   if (NUM_SRC <= NUM_EXT) begin : g_bad_src
      $error("irq_ctrl: NUM_SRC must exceed the external source count");
   end
   if (VEC_BASE + VEC_STRIDE * (NUM_SRC - 1) >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_ctrl: vector table does not fit VEC_W");
   end

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] clr;
   logic               found;
   logic [SRC_W-1:0]   win_src;
   logic [LVL_W-1:0]   win_lvl;
   logic               busy;
   logic [LVL_W-1:0]   top_lvl;
   logic               allow;
   logic               grant;

   irq_flags #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) flags_i (
      .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .ext_n(ext_n),
      .ext_edge(ext_edge), .clr(clr), .req(req_flags)
   );

   irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) arb_i (
      .cand(pend_q & src_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
      .found(found), .win_src(win_src), .win_lvl(win_lvl)
   );

   irq_inservice #(.NUM_LVL(NUM_LVL)) isr_i (
      .clk(clk), .rst_n(rst_n), .grant(grant), .grant_lvl(win_lvl),
      .reti(reti_pulse), .isr(in_service), .busy(busy), .top_lvl(top_lvl)
   );

   assign allow = !busy || (win_lvl > top_lvl);
   assign grant = insn_boundary && !cfg_write && !reti_pulse && found && allow;
   assign clr   = grant ? (NUM_SRC'(1) << win_src) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= '0;
         ack_valid <= 1'b0;
         ack_src   <= '0;
         ack_level <= '0;
         ack_vec   <= '0;
      end else begin
         pend_q    <= (sample_tick ? req_flags : pend_q) & ~clr;
         ack_valid <= grant;
         if (grant) begin
            ack_src   <= win_src;
            ack_level <= win_lvl;
            ack_vec   <= VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_src));
         end
      end
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int NUM_SRC = 11,
   parameter int NUM_LVL = 4,
   parameter int SRC_W   = 4,
   parameter int LVL_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         ext_n,
   input logic [1:0]         ext_edge,
   input logic [NUM_SRC-1:0] src_en,
   input logic               insn_boundary,
   input logic               cfg_write,
   input logic               reti_pulse,
   input logic [NUM_SRC-1:0] req_flags,
   input logic               ack_valid,
   input logic [SRC_W-1:0]   ack_src,
   input logic [LVL_W-1:0]   ack_level,
   input logic [NUM_LVL-1:0] in_service
);
   logic               seen_q;
   logic [NUM_SRC-1:0] en_d;
   logic [NUM_LVL-1:0] isr_d;
   logic               pin0_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         en_d   <= '0;
         isr_d  <= '0;
         pin0_d <= 1'b1;
      end else begin
         seen_q <= 1'b1;
         en_d   <= src_en;
         isr_d  <= in_service;
         pin0_d <= ext_n[0];
      end
   end

   p_ack_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> en_d[ack_src]);

   p_ack_marks_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> in_service[ack_level]);

   p_strictly_higher_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && seen_q) |-> ((isr_d >> ack_level) == '0));

   p_ack_unblocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> ($past(insn_boundary) && !$past(cfg_write) && !$past(reti_pulse)));

   p_reti_pops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_pulse && in_service != '0) |=>
         ($countones(in_service) + 1 == $countones($past(in_service))));

   p_level_follows_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !ext_edge[0]) |-> (req_flags[0] == !pin0_d));
endmodule

bind irq_ctrl irq_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LVL_W(LVL_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
   .src_en(src_en), .insn_boundary(insn_boundary), .cfg_write(cfg_write),
   .reti_pulse(reti_pulse), .req_flags(req_flags), .ack_valid(ack_valid),
   .ack_src(ack_src), .ack_level(ack_level), .in_service(in_service)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-3:0] int_evt = '0;
   logic [1:0]    ext_n = 2'b11;
   logic [1:0]    ext_edge = 2'b11;
   logic [NS-1:0] src_en = '0, prio_hi = '0, prio_lo = '0;
   logic          sample_tick = 0, insn_boundary = 0, cfg_write = 0, reti_pulse = 0;
   logic [NS-1:0] req_flags;
   logic          ack_valid;
   logic [3:0]    ack_src;
   logic [1:0]    ack_level;
   logic [15:0]   ack_vec;
   logic [3:0]    in_service;

   int checks = 0, failures = 0;

   // reference model state
   logic [1:0]    m_pinq;
   logic [NS-1:0] m_flag, m_pend;
   logic [3:0]    m_isr;
   logic          m_ack;
   logic [3:0]    m_src;
   logic [1:0]    m_lvl;
   logic [15:0]   m_vec;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .int_evt(int_evt), .ext_n(ext_n), .ext_edge(ext_edge),
      .src_en(src_en), .prio_hi(prio_hi), .prio_lo(prio_lo), .sample_tick(sample_tick),
      .insn_boundary(insn_boundary), .cfg_write(cfg_write), .reti_pulse(reti_pulse),
      .req_flags(req_flags), .ack_valid(ack_valid), .ack_src(ack_src),
      .ack_level(ack_level), .ack_vec(ack_vec), .in_service(in_service)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [NS-1:0] model_req();
      logic [NS-1:0] r;
      for (int i = 0; i < NS; i++) r[i] = m_flag[i];
      for (int k = 0; k < 2; k++) r[k] = ext_edge[k] ? m_flag[k] : ~m_pinq[k];
      return r;
   endfunction

   function automatic int top_of(input logic [3:0] m);
      for (int l = 3; l >= 0; l--) if (m[l]) return l;
      return -1;
   endfunction

   task automatic model_reset();
      m_pinq = 2'b11; m_flag = '0; m_pend = '0; m_isr = '0;
      m_ack = 0; m_src = '0; m_lvl = '0; m_vec = '0;
   endtask

   // one clock: predict, advance, compare all outputs
   task automatic step(input string tag);
      logic [NS-1:0] rq, cand, clr;
      int win, wl;
      logic grant;
      rq = model_req();
      cand = m_pend & src_en;
      win = -1; wl = 0;
      for (int l = 3; l >= 0 && win < 0; l--)
         for (int i = 0; i < NS && win < 0; i++)
            if (cand[i] && {prio_hi[i], prio_lo[i]} == 2'(l)) begin win = i; wl = l; end
      grant = insn_boundary && !cfg_write && !reti_pulse && win >= 0 && (wl > top_of(m_isr));
      clr = grant ? (NS'(1) << win) : '0;
      @(posedge clk);
      #1;
      if (rst_n) begin
         for (int k = 0; k < 2; k++)
            m_flag[k] = ext_edge[k] ? ((m_pinq[k] & ~ext_n[k]) | (m_flag[k] & ~clr[k])) : 1'b0;
         for (int i = 2; i < NS; i++) m_flag[i] = int_evt[i-2] | (m_flag[i] & ~clr[i]);
         m_pinq = ext_n;
         m_pend = (sample_tick ? rq : m_pend) & ~clr;
         m_ack = grant;
         if (grant) begin
            m_src = 4'(win); m_lvl = 2'(wl); m_vec = 16'(3 + 8 * win);
            m_isr[wl] = 1'b1;
         end else if (reti_pulse && m_isr != 0) m_isr[top_of(m_isr)] = 1'b0;
      end else model_reset();
      check(tag, "ack_valid", ack_valid, m_ack);
      check(tag, "ack_src", ack_src, m_src);
      check(tag, "ack_level", ack_level, m_lvl);
      check(tag, "ack_vec", ack_vec, m_vec);
      check(tag, "in_service", in_service, m_isr);
      check(tag, "req_flags", req_flags, model_req());
      @(negedge clk);
   endtask

   task automatic idle();
      int_evt = '0; sample_tick = 0; insn_boundary = 0; cfg_write = 0; reti_pulse = 0;
   endtask

   task automatic poll(input string tag, input int n);
      sample_tick = 1; insn_boundary = 1;
      for (int i = 0; i < n; i++) step(tag);
      idle();
   endtask

   task automatic reti_once(input string tag);
      reti_pulse = 1; step(tag); reti_pulse = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      model_reset();
      @(negedge clk);
      step("R1"); step("R1");
      rst_n = 1;
      check("R1", "ack_valid", ack_valid, 0);
      check("R1", "in_service", in_service, 0);
      check("R1", "req_flags", req_flags, 0);
      check("R1", "ack_vec", ack_vec, 0);

      // flag rises with source disabled; never granted
      int_evt = 9'b0_0000_0010; step("R2"); int_evt = '0;
      check("R2", "req_flags[3]", req_flags[3], 1);
      poll("R4", 3);
      check("R4", "ack_valid", ack_valid, 0);

      // snapshot timing and vector of source 10
      src_en = NS'(1) << 10;
      int_evt = 9'b1_0000_0000; step("R3"); int_evt = '0;
      insn_boundary = 1; step("R3");
      sample_tick = 1; step("R3");
      sample_tick = 0; step("R6");
      check("R6", "ack_valid", ack_valid, 1);
      check("R6", "ack_src", ack_src, 10);
      check("R6", "ack_vec", ack_vec, 83);
      idle(); step("R6");
      reti_once("R9");
      check("R9", "in_service", in_service, 0);

      // nesting: src4 lvl1, src7 lvl1, src6 lvl2
      src_en = src_en | NS'(11'b000_1101_0000);
      prio_lo[4] = 1; prio_lo[7] = 1; prio_hi[6] = 1;
      int_evt = 9'b0_0000_0100; step("R7"); idle(); poll("R7", 4);
      int_evt = 9'b0_0010_0000; step("R7"); idle(); poll("R7", 4);
      int_evt = 9'b0_0001_0000; step("R7"); idle(); poll("R7", 4);
      check("R7", "in_service", in_service, 4'b0110);
      reti_once("R9");
      check("R9", "in_service", in_service, 4'b0010);
      reti_once("R9");

      // blocked acknowledge, src7 still pending
      insn_boundary = 1; cfg_write = 1; step("R8"); cfg_write = 0;
      reti_pulse = 1; step("R8"); reti_pulse = 0;
      step("R8"); idle(); step("R8");
      reti_once("R9");

      // tie at level 3, with a new event on the winner during its grant
      src_en = src_en | NS'(11'b011_0000_0000);
      prio_hi[8] = 1; prio_lo[8] = 1; prio_hi[9] = 1; prio_lo[9] = 1;
      int_evt = 9'b0_1100_0000; step("R5"); idle();
      sample_tick = 1; step("R5");
      sample_tick = 0; insn_boundary = 1; int_evt = 9'b0_0100_0000; step("R12");
      check("R5", "ack_src", ack_src, 8);
      idle(); step("R12"); reti_once("R12");

      // external pins: edge on pin 0, level on pin 1
      src_en = src_en | NS'(3); prio_hi[0] = 1; prio_lo[0] = 1; prio_hi[1] = 1; prio_lo[1] = 1;
      ext_n[0] = 0; step("R10"); ext_n[0] = 1; step("R10");
      poll("R10", 4); reti_once("R10"); poll("R10", 3); reti_once("R10");
      ext_edge[1] = 0; ext_n[1] = 0; step("R11");
      poll("R11", 4);
      check("R11", "req_flags[1]", req_flags[1], 1);
      ext_n[1] = 1; step("R11"); reti_once("R11"); reti_once("R11");

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int_evt = ($urandom % 4 == 0) ? 9'($urandom) : '0;
         if ($urandom % 8 == 0) ext_n = 2'($urandom);
         if ($urandom % 64 == 0) ext_edge = 2'($urandom);
         if ($urandom % 32 == 0) begin
            src_en = NS'($urandom); prio_hi = NS'($urandom); prio_lo = NS'($urandom);
         end
         sample_tick   = ($urandom % 3 == 0);
         insn_boundary = ($urandom % 2 == 0);
         cfg_write     = ($urandom % 10 == 0);
         reti_pulse    = ($urandom % 6 == 0);
         step("R5");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule